// File: doc/BRIEF.md
# Burst Read Master Controller

This block sits on the master side of a synchronous point-to-point core interface and reads a block of bytes from a slave. A client gives a start pulse, a byte total and a base address. The controller then cuts the total into bursts of at most eight bytes. Each burst is a read request that the slave must accept. The slave answers with one or more response beats. Every accepted beat is forwarded on an outbound valid/data stream, with a byte-keep mask that marks which lanes of the word carry real bytes.

The controller is a three-state machine. **IDLE** waits for work. **DRIVE** presents one read request and holds it until the slave accepts it. **CAPTURE** collects the response beats of that burst.

The transitions are:
- **IDLE→DRIVE** (start with a nonzero total).
- **DRIVE→DRIVE** (command not accepted).
- **DRIVE→CAPTURE** (command accepted).
- **CAPTURE→CAPTURE** (final beat not yet seen).
- **CAPTURE→DRIVE** (final beat taken, bytes remain).
- **CAPTURE→IDLE** (final beat taken, nothing remains).

A remaining-byte counter decides which of the last two applies. After each burst the request address moves up by eight.

Top module: `burst_read_master`

## Requirements
- R1: After an active-low synchronous reset, `busy`, `req_qual`, `resp_accept` and `out_valid` are 0 and `req_cmd` is the idle code 3'b000; whenever `busy` is 0, `req_cmd` is idle and `resp_accept` is 0.
- R2: A `start` pulse with a nonzero `total_bytes` makes `busy` rise and a request appear on the next cycle; a `start` with `total_bytes` of 0 is ignored, and `busy` stays 0.
- R3: In DRIVE the block shows `req_cmd` = 3'b010 (read), `req_qual` = 1 and the burst's address, length and size, and holds all of them unchanged for as long as `cmd_accept` is 0.
- R4: A cycle with `req_qual` and `cmd_accept` both 1 moves the block to CAPTURE, so in the next cycle `req_qual` is 0, `req_cmd` is idle and `resp_accept` is 1.
- R5: In CAPTURE, `resp_accept` stays at 1. A beat is taken only when `data_accept` is 1 and `resp` is 2'b01 (data valid). A beat with any other `resp` code, or with `data_accept` at 0, produces no output and does not advance the burst.
- R6: A taken beat with `resp_last` = 1 ends the burst. If no bytes remain the block returns to IDLE on the next cycle, otherwise it presents the next request on the next cycle, with no idle cycle between bursts.
- R7: Each burst's `req_size` is the smaller of 8 and the bytes still remaining. `req_len` is `req_size` divided by 4 and rounded up. The first burst's `req_addr` is `base_addr`, and each later burst adds 8.
- R8: `req_lanes` bit i is 1 exactly when i < `req_size`, so a short final burst masks its unused byte lanes.
- R9: One cycle after each taken beat, `out_valid` is 1 for that cycle with `out_data` equal to the beat's `rd_data`. `out_keep` bit j is 1 exactly when beat_index*4 + j < burst size, where beat_index is 0 for the first beat of a burst.
- R10: A `start` pulse while `busy` is 1 is ignored; the running transfer carries on with its original total and address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for every register |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a transfer |
| total_bytes | input | CNT_W | Number of bytes to read |
| base_addr | input | ADDR_W | Byte address of the first burst |
| busy | output | 1 | High while a transfer is in progress |
| req_cmd | output | 3 | Command code: 3'b000 idle, 3'b010 read |
| req_addr | output | ADDR_W | Burst start address |
| req_len | output | clog2(BURST_BYTES/(DATA_W/8)+1) | Beats in this burst |
| req_size | output | clog2(BURST_BYTES+1) | Bytes in this burst |
| req_lanes | output | BURST_BYTES | Byte-lane enables for the burst |
| req_qual | output | 1 | Qualifier: request fields are valid |
| cmd_accept | input | 1 | Slave accepts the presented request |
| data_accept | input | 1 | Slave marks the current beat as transferred |
| resp | input | 2 | Response code: 2'b01 data valid, others carry no data |
| resp_last | input | 1 | Final beat of the burst |
| rd_data | input | DATA_W | Read data of the beat |
| resp_accept | output | 1 | Master acknowledges response beats |
| out_valid | output | 1 | Outbound word valid |
| out_data | output | DATA_W | Outbound word |
| out_keep | output | DATA_W/8 | Valid byte lanes of the outbound word |

## Verification
The bench goes after these corner cases:
- **Held requests.** The slave holds off command acceptance for several cycles. A design that let address or size drift while waiting would be seen by the slave model.
- **Short final bursts.** Totals of 3, 13 and 100 end in 3-, 5- and 4-byte bursts. A design with wrong rounding would emit the wrong beat count or keep mask, and a design with a faulty remainder subtraction would issue the wrong number of bursts.
- **Ignored beats.** Error-coded beats and beats without the accept flag are injected. A design that forwarded them would push unexpected words into the stream.
- **Burst boundaries and stray starts.** Checks right after each final beat catch an idle gap between bursts or a missed return to idle. A start pulse in the middle of a transfer catches a design that reloads its counter.

// File: rtl/brm_pkg.sv
package brm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DRIVE   = 2'd1,
        ST_CAPTURE = 2'd2
    } brm_state_e;

    localparam logic [2:0] CMD_IDLE = 3'b000;
    localparam logic [2:0] CMD_READ = 3'b010;

    localparam logic [1:0] RSP_NONE = 2'b00;
    localparam logic [1:0] RSP_DVA  = 2'b01;
    localparam logic [1:0] RSP_ERR  = 2'b11;
endpackage

// File: rtl/brm_burst_calc.sv
module brm_burst_calc #(
    parameter int CNT_W       = 16,
    parameter int BURST_BYTES = 8,
    parameter int BEAT_BYTES  = 4,
    localparam int SZ_W       = $clog2(BURST_BYTES + 1),
    localparam int LEN_W      = $clog2(BURST_BYTES / BEAT_BYTES + 1)
) (
    input  logic [CNT_W-1:0]       remaining,
    output logic [SZ_W-1:0]        size,
    output logic [LEN_W-1:0]       beats,
    output logic [BURST_BYTES-1:0] lanes
);
    always_comb begin
        if (remaining >= CNT_W'(BURST_BYTES))
            size = SZ_W'(BURST_BYTES);
        else
            size = remaining[SZ_W-1:0];
        beats = LEN_W'((int'(size) + BEAT_BYTES - 1) / BEAT_BYTES);
    end

    for (genvar i = 0; i < BURST_BYTES; i++) begin : g_lane
        assign lanes[i] = (int'(size) > i);
    end
endmodule

// File: rtl/brm_capture.sv
module brm_capture #(
    parameter int DATA_W      = 32,
    parameter int BURST_BYTES = 8,
    localparam int BEAT_BYTES = DATA_W / 8,
    localparam int SZ_W       = $clog2(BURST_BYTES + 1),
    localparam int LEN_W      = $clog2(BURST_BYTES / BEAT_BYTES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  active,
    input  logic                  clear,
    input  logic [SZ_W-1:0]       burst_size,
    input  logic                  data_accept,
    input  logic [1:0]            resp,
    input  logic                  resp_last,
    input  logic [DATA_W-1:0]     rd_data,
    output logic                  burst_end,
    output logic                  out_valid,
    output logic [DATA_W-1:0]     out_data,
    output logic [BEAT_BYTES-1:0] out_keep
);
    import brm_pkg::*;

    logic                  beat_take;
    logic [LEN_W-1:0]      beat_idx;
    logic [BEAT_BYTES-1:0] keep_nxt;

    assign beat_take = active && data_accept && (resp == RSP_DVA);
    assign burst_end = beat_take && resp_last;

    for (genvar j = 0; j < BEAT_BYTES; j++) begin : g_keep
        assign keep_nxt[j] = (int'(beat_idx) * BEAT_BYTES + j) < int'(burst_size);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_idx  <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_keep  <= '0;
        end else begin
            if (clear)
                beat_idx <= '0;
            else if (beat_take)
                beat_idx <= beat_idx + 1'b1;
            out_valid <= beat_take;
            if (beat_take) begin
                out_data <= rd_data;
                out_keep <= keep_nxt;
            end
        end
    end

    // R5: beats without a data-valid code never reach the stream
    assert_ignore_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && resp != RSP_DVA) |=> !out_valid);
endmodule

// File: rtl/burst_read_master.sv
module burst_read_master #(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 32,
    parameter int BURST_BYTES = 8
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          start,
    input  logic [CNT_W-1:0]                              total_bytes,
    input  logic [ADDR_W-1:0]                             base_addr,
    output logic                                          busy,
    output logic [2:0]                                    req_cmd,
    output logic [ADDR_W-1:0]                             req_addr,
    output logic [$clog2(BURST_BYTES/(DATA_W/8)+1)-1:0]   req_len,
    output logic [$clog2(BURST_BYTES+1)-1:0]              req_size,
    output logic [BURST_BYTES-1:0]                        req_lanes,
    output logic                                          req_qual,
    input  logic                                          cmd_accept,
    input  logic                                          data_accept,
    input  logic [1:0]                                    resp,
    input  logic                                          resp_last,
    input  logic [DATA_W-1:0]                             rd_data,
    output logic                                          resp_accept,
    output logic                                          out_valid,
    output logic [DATA_W-1:0]                             out_data,
    output logic [DATA_W/8-1:0]                           out_keep
);
    import brm_pkg::*;

    localparam int BEAT_BYTES = DATA_W / 8;
    localparam int SZ_W       = $clog2(BURST_BYTES + 1);
    localparam int LEN_W      = $clog2(BURST_BYTES / BEAT_BYTES + 1);

    brm_state_e              state_q, state_d;
    logic [CNT_W-1:0]        rem_q;
    logic [ADDR_W-1:0]       addr_q;
    logic [SZ_W-1:0]         size_q;
    logic [SZ_W-1:0]         cur_size;
    logic [LEN_W-1:0]        cur_len;
    logic [BURST_BYTES-1:0]  cur_lanes;
    logic                    launch, granted, burst_end;

    assign launch  = (state_q == ST_IDLE) && start && (total_bytes != '0);
    assign granted = (state_q == ST_DRIVE) && cmd_accept;

    brm_burst_calc #(
        .CNT_W(CNT_W), .BURST_BYTES(BURST_BYTES), .BEAT_BYTES(BEAT_BYTES)
    ) u_calc (
        .remaining(rem_q), .size(cur_size), .beats(cur_len), .lanes(cur_lanes)
    );

    brm_capture #(
        .DATA_W(DATA_W), .BURST_BYTES(BURST_BYTES)
    ) u_capture (
        .clk(clk), .rst_n(rst_n),
        .active(state_q == ST_CAPTURE), .clear(granted),
        .burst_size(size_q), .data_accept(data_accept), .resp(resp),
        .resp_last(resp_last), .rd_data(rd_data), .burst_end(burst_end),
        .out_valid(out_valid), .out_data(out_data), .out_keep(out_keep)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transition logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (launch)    state_d = ST_DRIVE;
            ST_DRIVE:   if (cmd_accept) state_d = ST_CAPTURE;
            ST_CAPTURE: if (burst_end) state_d = (rem_q == '0) ? ST_IDLE : ST_DRIVE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // byte counter, address and captured burst size
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            addr_q <= '0;
            size_q <= '0;
        end else if (launch) begin
            rem_q  <= total_bytes;
            addr_q <= base_addr;
        end else if (granted) begin
            rem_q  <= rem_q - CNT_W'(cur_size);
            size_q <= cur_size;
            addr_q <= addr_q + ADDR_W'(BURST_BYTES);
        end
    end

    // outputs
    always_comb begin
        req_cmd     = CMD_IDLE;
        req_addr    = '0;
        req_len     = '0;
        req_size    = '0;
        req_lanes   = '0;
        req_qual    = 1'b0;
        resp_accept = 1'b0;
        busy        = 1'b1;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_DRIVE: begin
                req_cmd   = CMD_READ;
                req_qual  = 1'b1;
                req_addr  = addr_q;
                req_len   = cur_len;
                req_size  = cur_size;
                req_lanes = cur_lanes;
            end
            ST_CAPTURE: resp_accept = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    // R1: an idle block shows no command and no response acknowledge
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (req_cmd == CMD_IDLE && !resp_accept));

    // R3: request held unchanged while the slave withholds acceptance
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_qual && !cmd_accept) |=> (req_qual && $stable(req_addr) && $stable(req_size) && $stable(req_lanes)));

    // R4: an accepted request is withdrawn and capture begins
    assert_grant_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_qual && cmd_accept) |=> (!req_qual && resp_accept));

    // R7: burst size never zero and never above the burst limit
    assert_size_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_qual |-> (req_size != '0 && int'(req_size) <= BURST_BYTES));
endmodule

// File: tb/tb_burst_read_master.sv
module tb_burst_read_master;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 32;
    localparam int BB     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [CNT_W-1:0]  total_bytes = '0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic              busy;
    logic [2:0]        req_cmd;
    logic [ADDR_W-1:0] req_addr;
    logic [1:0]        req_len;
    logic [3:0]        req_size;
    logic [7:0]        req_lanes;
    logic              req_qual;
    logic              cmd_accept = 1'b0;
    logic              data_accept = 1'b0;
    logic [1:0]        resp = 2'b00;
    logic              resp_last = 1'b0;
    logic [DATA_W-1:0] rd_data = '0;
    logic              resp_accept;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;
    logic [3:0]        out_keep;

    burst_read_master #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .BURST_BYTES(BB)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .total_bytes(total_bytes),
        .base_addr(base_addr), .busy(busy), .req_cmd(req_cmd), .req_addr(req_addr),
        .req_len(req_len), .req_size(req_size), .req_lanes(req_lanes), .req_qual(req_qual),
        .cmd_accept(cmd_accept), .data_accept(data_accept), .resp(resp),
        .resp_last(resp_last), .rd_data(rd_data), .resp_accept(resp_accept),
        .out_valid(out_valid), .out_data(out_data), .out_keep(out_keep)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pattern(input logic [31:0] a, input int k);
        return {a[15:0] ^ 16'h3C00, 8'h5A, 8'(k)};
    endfunction

    // scoreboard queues
    logic [31:0] exp_addr_q[$];
    logic [3:0]  exp_size_q[$];
    logic [1:0]  exp_len_q[$];
    logic [7:0]  exp_lanes_q[$];
    bit          exp_more_q[$];
    logic [31:0] exp_data_q[$];
    logic [3:0]  exp_keep_q[$];

    // slave model configuration
    int stall_cfg = 0;
    bit gap_cfg   = 1'b0;
    bit err_cfg   = 1'b0;

    // slave model state
    int          mode = 0;
    bit          seen = 1'b0;
    int          wait_left = 0;
    int          beat = 0;
    bit          gap_tgl = 1'b0;
    bit          err_pend = 1'b0;
    logic [31:0] cur_addr;
    logic [3:0]  cur_size;
    logic [1:0]  cur_len;
    logic [7:0]  cur_lanes;
    bit          cur_more;

    // slave model: drives inputs on the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            mode = 0; seen = 0;
            cmd_accept = 0; data_accept = 0; resp = 2'b00; resp_last = 0;
        end else begin
            case (mode)
                0: begin
                    if (cmd_accept) begin
                        cmd_accept = 0;
                        chk(req_cmd == 3'b000 && !req_qual && resp_accept, "R4 capture after accept",
                            {28'd0, req_cmd, resp_accept}, 32'h1);
                        mode = 1; beat = 0; gap_tgl = 0; err_pend = err_cfg;
                    end else if (req_cmd == 3'b010) begin
                        if (!seen) begin
                            seen = 1;
                            if (exp_addr_q.size() == 0) begin
                                chk(0, "R7 unexpected request", req_addr, 32'h0);
                                cur_addr = req_addr; cur_size = req_size; cur_len = req_len;
                                cur_lanes = req_lanes; cur_more = 0;
                            end else begin
                                cur_addr = exp_addr_q.pop_front();
                                cur_size = exp_size_q.pop_front();
                                cur_len  = exp_len_q.pop_front();
                                cur_lanes = exp_lanes_q.pop_front();
                                cur_more = exp_more_q.pop_front();
                                chk(req_addr == cur_addr, "R7 address", req_addr, cur_addr);
                                chk(req_size == cur_size, "R7 size", {28'd0, req_size}, {28'd0, cur_size});
                                chk(req_len == cur_len, "R7 length", {30'd0, req_len}, {30'd0, cur_len});
                                chk(req_lanes == cur_lanes, "R8 lanes", {24'd0, req_lanes}, {24'd0, cur_lanes});
                                chk(req_qual, "R3 qualifier", {31'd0, req_qual}, 32'h1);
                            end
                            wait_left = stall_cfg;
                        end else begin
                            chk(req_addr == cur_addr && req_size == cur_size && req_lanes == cur_lanes,
                                "R3 hold while waiting", req_addr, cur_addr);
                        end
                        if (wait_left == 0) cmd_accept = 1;
                        else wait_left--;
                    end
                end
                1: begin
                    chk(resp_accept, "R5 resp_accept in capture", {31'd0, resp_accept}, 32'h1);
                    data_accept = 0; resp = 2'b00; resp_last = 0;
                    if (err_pend) begin
                        err_pend = 0;
                        data_accept = 1; resp = 2'b11; rd_data = 32'hDEAD_BEEF;
                    end else if (gap_cfg && gap_tgl) begin
                        gap_tgl = 0;
                        resp = 2'b01; rd_data = 32'hBAD0_0000;
                    end else begin
                        gap_tgl = 1;
                        data_accept = 1; resp = 2'b01;
                        rd_data = pattern(cur_addr, beat);
                        resp_last = (beat == int'(cur_len) - 1);
                        if (resp_last) mode = 2;
                        beat++;
                    end
                end
                default: begin
                    data_accept = 0; resp = 2'b00; resp_last = 0;
                    seen = 0;
                    if (cur_more)
                        chk(req_cmd == 3'b010 && busy, "R6 next burst without idle",
                            {29'd0, req_cmd}, 32'h2);
                    else
                        chk(req_cmd == 3'b000 && !busy, "R6 return to idle",
                            {28'd0, req_cmd, busy}, 32'h0);
                    mode = 0;
                end
            endcase
        end
    end

    // monitor: compares the outbound stream with the scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_data_q.size() == 0) begin
                chk(0, "R5/R9 unexpected output word", out_data, 32'h0);
            end else begin
                logic [31:0] ed;
                logic [3:0]  ek;
                ed = exp_data_q.pop_front();
                ek = exp_keep_q.pop_front();
                chk(out_data == ed, "R9 data", out_data, ed);
                chk(out_keep == ek, "R9 keep", {28'd0, out_keep}, {28'd0, ek});
            end
        end
    end

    task automatic plan_xfer(input logic [31:0] base, input int total);
        int rem = total;
        logic [31:0] a = base;
        while (rem > 0) begin
            int sz  = (rem >= BB) ? BB : rem;
            int len = (sz + 3) / 4;
            exp_addr_q.push_back(a);
            exp_size_q.push_back(4'(sz));
            exp_len_q.push_back(2'(len));
            exp_lanes_q.push_back(8'((1 << sz) - 1));
            exp_more_q.push_back(rem > sz);
            for (int k = 0; k < len; k++) begin
                int nb = sz - 4 * k;
                if (nb > 4) nb = 4;
                exp_data_q.push_back(pattern(a, k));
                exp_keep_q.push_back(4'((1 << nb) - 1));
            end
            rem -= sz;
            a += 32'(BB);
        end
    endtask

    task automatic run_xfer(input logic [31:0] base, input int total, input string tag,
                            input bit restart);
        int guard = 0;
        plan_xfer(base, total);
        @(negedge clk);
        start = 1; total_bytes = 16'(total); base_addr = base;
        @(negedge clk);
        start = 0;
        chk(busy, {"R2 busy after start ", tag}, {31'd0, busy}, 32'h1);
        if (restart) begin
            repeat (3) @(negedge clk);
            start = 1; total_bytes = 16'd40; base_addr = 32'h0000_9000; // R10 stray start
            @(negedge clk);
            start = 0;
        end
        while ((busy || mode != 0 || exp_data_q.size() != 0) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        chk(exp_data_q.size() == 0 && exp_addr_q.size() == 0, {"R6/R10 all words delivered ", tag},
            32'(exp_data_q.size()), 32'h0);
        chk(!busy && req_cmd == 3'b000, {"R6 idle at end ", tag}, {31'd0, busy}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && req_cmd == 3'b000 && !req_qual && !resp_accept && !out_valid,
            "R1 reset state", {27'd0, busy, req_cmd, out_valid}, 32'h0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !resp_accept, "R1 idle after reset", {31'd0, busy}, 32'h0);

        // R2: zero total is ignored
        start = 1; total_bytes = 16'd0; base_addr = 32'h40;
        @(negedge clk);
        start = 0;
        repeat (3) begin
            @(negedge clk);
            chk(!busy && req_cmd == 3'b000, "R2 zero total ignored", {31'd0, busy}, 32'h0);
        end

        // single full burst, no stalls
        stall_cfg = 0; gap_cfg = 0; err_cfg = 0;
        run_xfer(32'h0000_1000, 8, "8B", 0);

        // tiny transfer: one short beat
        run_xfer(32'h0000_2000, 3, "3B", 0);

        // full then short burst, with command stalls (R3 hold)
        stall_cfg = 3;
        run_xfer(32'h0000_3000, 13, "13B", 0);

        // long transfer with gaps and error beats (R5) and back-to-back bursts (R6)
        stall_cfg = 0; gap_cfg = 1; err_cfg = 1;
        run_xfer(32'h0000_4000, 100, "100B", 0);

        // start while busy must be ignored (R10)
        stall_cfg = 1; gap_cfg = 0; err_cfg = 0;
        run_xfer(32'h0000_5000, 16, "16B", 1);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule